// File: doc/BRIEF.md
# Supply-Sequencing and Auto-Restart Controller

This block sequences an offline switching converter through its supply life cycle. It watches comparator flags taken from the controller supply pin, an input-voltage-sufficient flag and four protection inputs. From these it decides when the high-voltage startup charger runs and at which current, when the power switch may operate, and how fast the cycle-by-cycle current limit opens up after each start.

The first power-up charges the supply capacitor at the fast current. Reaching the startup threshold turns the charger off and enables switching. The current-limit code then climbs from zero to full scale over a soft-start window.

An undervoltage while switching ends operation for good, until reset. Any other protection stops switching and lets the supply decay. Once the supply is below the restart threshold, the charger resumes at the reduced current, and the next start repeats the soft-start ramp.

A peak-overcurrent event counts as a fault only when it is seen on two switching cycles in a row. That fault stays latched until the supply falls below the undervoltage level. Over-temperature is held with hysteresis between a trip flag and a release flag.

Top module: `supply_seq_ctrl`

## Requirements
- R1: After reset the block is in the fast-charge state: `sw_en`=0, `chg_fast`=1, `ilim`=0, `fault_code`=0.
- R2: `chg_en` is 1 only while the block is in a charging state (first or post-fault) and `vin_ok` is 1; it follows `vin_ok` in the same cycle.
- R3: In a charging state, `vdd_above_on`=1 at a clock edge sets `sw_en`=1 and `chg_en`=0 after that edge.
- R4: `ilim` is 0 whenever `sw_en` is 0. On the edge that enables switching it is 0, then it rises by one every STEP clocks up to 2^ILIM_W-1 and holds there. STEP is SS_CYCLES/(2^ILIM_W-1), with a minimum of 1; the defaults give STEP 10 and a full scale of 63.
- R5: `vdd_below_uv`=1 while switching stops switching at that edge, and this takes precedence over any fault in the same cycle. Switching and the charger then stay off until reset, whatever the other inputs do.
- R6: `ov_fault`, `ol_fault` or an active thermal flag while switching stops switching. The charger stays off until `vdd_below_rst` is seen. The block then enters the post-fault charging state, in which `chg_fast`=0.
- R7: Every start after a fault runs the soft-start ramp again from code 0.
- R8: `pk_hit` is sampled only on cycles where `cycle_tick`=1. A hit on two consecutive sampled cycles is a peak-overcurrent fault. A clean sampled cycle between two hits prevents the fault.
- R9: After a peak-overcurrent fault, switching and the charger stay off and `vdd_below_rst` is ignored until `vdd_below_uv`=1. From then on the block behaves as after the other faults.
- R10: The thermal flag is set by `hot_trip` and cleared only by `cool_ok`. While it is set, each switching start ends in a fault on the following edge.
- R11: Fault inputs have no effect while the block is in a charging state.
- R12: `fault_code` records the first fault after reset and then holds. The codes are 1 for overvoltage, 2 for overload, 3 for peak overcurrent and 4 for thermal. When several faults arrive together, the priority is peak overcurrent, then thermal, then overload, then overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Input voltage high enough for the charger |
| vdd_above_on | input | 1 | Supply above startup threshold |
| vdd_below_uv | input | 1 | Supply below undervoltage threshold |
| vdd_below_rst | input | 1 | Supply below restart threshold |
| cycle_tick | input | 1 | One pulse per switching cycle |
| pk_hit | input | 1 | Peak current exceeded the high threshold this cycle |
| ov_fault | input | 1 | Output overvoltage fault |
| ol_fault | input | 1 | Overload timeout fault |
| hot_trip | input | 1 | Temperature above trip level |
| cool_ok | input | 1 | Temperature below release level |
| chg_en | output | 1 | Startup charger enable |
| chg_fast | output | 1 | Charger current select: 1 fast, 0 reduced |
| sw_en | output | 1 | Switching enable |
| ilim | output | ILIM_W | Current-limit reference code |
| fault_code | output | 3 | First recorded fault |

## Verification
The bench drives a first power-up with faults present during charging, a long run that reaches full soft-start scale, and several restarts. Separate sequences test single, isolated and back-to-back peak-overcurrent hits, which distinguish a one-cycle warning from a real fault. Restart-threshold and undervoltage flags are raised in both orders against the latched state, which tells the latch apart from an ordinary fault wait. Thermal trip, hold and release, and coincident undervoltage with a fault, check the state priorities. A fresh reset with coincident faults checks the priority of the recorded code.

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl #(
  parameter int ILIM_W    = 6,
  parameter int SS_CYCLES = 630
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vin_ok,
  input  logic              vdd_above_on,
  input  logic              vdd_below_uv,
  input  logic              vdd_below_rst,
  input  logic              cycle_tick,
  input  logic              pk_hit,
  input  logic              ov_fault,
  input  logic              ol_fault,
  input  logic              hot_trip,
  input  logic              cool_ok,
  output logic              chg_en,
  output logic              chg_fast,
  output logic              sw_en,
  output logic [ILIM_W-1:0] ilim,
  output logic [2:0]        fault_code
);

  localparam int LIM_MAX = (1 << ILIM_W) - 1;
  localparam int STEP    = (SS_CYCLES / LIM_MAX < 1) ? 1 : SS_CYCLES / LIM_MAX;
  localparam int CNT_W   = $clog2(STEP + 1);

  typedef enum logic [2:0] {
    S_CHG_FAST, S_RUN, S_WAIT, S_CHG_SLOW, S_PK_LATCH, S_UV_STOP
  } st_t;

  st_t               st_q, st_d;
  logic              warn_q, therm_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ILIM_W-1:0] lim_q;
  logic [2:0]        code_q, cause;

  wire therm_now = hot_trip | (therm_q & ~cool_ok);
  wire charging  = (st_q == S_CHG_FAST) || (st_q == S_CHG_SLOW);
  wire running   = (st_q == S_RUN);
  wire pk_flt    = cycle_tick & pk_hit & warn_q;
  wire other_flt = ov_fault | ol_fault | therm_now;

  always_comb begin
    if (pk_flt)        cause = 3'd3;
    else if (therm_now) cause = 3'd4;
    else if (ol_fault)  cause = 3'd2;
    else                cause = 3'd1;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_CHG_FAST, S_CHG_SLOW: if (vdd_above_on) st_d = S_RUN;
      S_RUN: begin
        if (vdd_below_uv)   st_d = S_UV_STOP;
        else if (pk_flt)    st_d = S_PK_LATCH;
        else if (other_flt) st_d = S_WAIT;
      end
      S_WAIT:     if (vdd_below_rst) st_d = S_CHG_SLOW;
      S_PK_LATCH: if (vdd_below_uv)  st_d = S_WAIT;
      default:    st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_CHG_FAST;
      warn_q  <= 1'b0;
      therm_q <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
      code_q  <= 3'd0;
    end else begin
      st_q    <= st_d;
      therm_q <= therm_now;
      if (!running)        warn_q <= 1'b0;
      else if (cycle_tick) warn_q <= pk_hit;
      if (!running || st_d != S_RUN) begin
        cnt_q <= '0;
        lim_q <= '0;
      end else if (lim_q != ILIM_W'(LIM_MAX)) begin
        if (cnt_q == CNT_W'(STEP - 1)) begin
          cnt_q <= '0;
          lim_q <= lim_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (running && st_d != S_RUN && st_d != S_UV_STOP && code_q == 3'd0)
        code_q <= cause;
    end
  end

  assign chg_en     = charging & vin_ok;
  assign chg_fast   = (st_q == S_CHG_FAST);
  assign sw_en      = running;
  assign ilim       = lim_q;
  assign fault_code = code_q;

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && chg_en));

  assert_lim_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> ilim == '0);

  assert_lim_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en && $past(sw_en) |-> (ilim == $past(ilim) || ilim == $past(ilim) + 1'b1));

  assert_uv_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en && vdd_below_uv |=> !sw_en && !chg_en);

  assert_fault_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en && (ov_fault || ol_fault) |=> !sw_en && !chg_en);

  assert_hot_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en && hot_trip |=> !sw_en);

  assert_chg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    charging && !vdd_above_on |=> $stable(st_q));

  assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code != 3'd0 |=> $stable(fault_code));

endmodule

// File: tb/supply_seq_ctrl_bench.sv
`timescale 1ns/1ps
module supply_seq_ctrl_bench;
  localparam int W = 6;
  localparam int SS = 630;
  localparam int MAXC = (1 << W) - 1;
  localparam int STEPC = (SS / MAXC < 1) ? 1 : SS / MAXC;

  logic clk = 0, rst_n = 0;
  logic vin_ok = 0, above = 0, uv = 0, brst = 0, ct = 0, pk = 0;
  logic ov = 0, ol = 0, hot = 0, cool = 0;
  logic chg_en, chg_fast, sw_en;
  logic [W-1:0] ilim;
  logic [2:0] fcode;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  supply_seq_ctrl #(.ILIM_W(W), .SS_CYCLES(SS)) u_supply_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .vdd_above_on(above),
    .vdd_below_uv(uv), .vdd_below_rst(brst), .cycle_tick(ct), .pk_hit(pk),
    .ov_fault(ov), .ol_fault(ol), .hot_trip(hot), .cool_ok(cool),
    .chg_en(chg_en), .chg_fast(chg_fast), .sw_en(sw_en), .ilim(ilim),
    .fault_code(fcode));

  // model states: 0 first charge, 1 run, 2 wait, 3 slow charge, 4 peak latch, 5 uv stop
  int mst = 0, mrun = 0, mcode = 0;
  bit mwarn = 0, mtherm = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mrun = 0; mcode = 0; mwarn = 0; mtherm = 0;
    end else begin
      bit tn, pkf;
      int nst;
      tn  = hot || (mtherm && !cool);
      pkf = ct && pk && mwarn;
      nst = mst;
      if ((mst == 0 || mst == 3) && above) nst = 1;
      else if (mst == 1) begin
        if (uv) nst = 5;
        else if (pkf) nst = 4;
        else if (ov || ol || tn) nst = 2;
      end
      else if (mst == 2 && brst) nst = 3;
      else if (mst == 4 && uv) nst = 2;
      if (mst == 1 && nst != 1 && nst != 5 && mcode == 0)
        mcode = pkf ? 3 : tn ? 4 : ol ? 2 : 1;
      if (mst == 1 && ct) mwarn = pk;
      else if (mst != 1) mwarn = 0;
      mrun = (mst == 1 && nst == 1) ? mrun + 1 : 0;
      mtherm = tn;
      mst = nst;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int el;
    el = (mst == 1) ? ((mrun / STEPC > MAXC) ? MAXC : mrun / STEPC) : 0;
    chk("R3 sw_en model", sw_en, mst == 1);
    chk("R2 chg_en model", chg_en, (mst == 0 || mst == 3) && vin_ok);
    chk("R6 chg_fast model", chg_fast, mst == 0);
    chk("R4 ilim model", ilim, el);
    chk("R12 fault_code model", fcode, mcode);
  end

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tk(3); #1 rst_n = 1;
    tk(1);
    chk("R1 sw_en", sw_en, 0); chk("R1 chg_fast", chg_fast, 1);
    chk("R1 ilim", ilim, 0); chk("R1 code", fcode, 0); chk("R2 chg_en vin low", chg_en, 0);
    #1 vin_ok = 1; ov = 1; ol = 1; ct = 1; pk = 1;
    tk(3);
    chk("R11 still charging", chg_en, 1); chk("R11 no switch", sw_en, 0); chk("R11 code", fcode, 0);
    #1 ov = 0; ol = 0; ct = 0; pk = 0; above = 1;
    tk(1);
    chk("R3 sw on", sw_en, 1); chk("R3 chg off", chg_en, 0);
    #1 above = 0;
    tk(700);
    chk("R4 full scale", ilim, MAXC);
    #1 ct = 1; pk = 1; tk(1);
    #1 ct = 0; tk(2);
    #1 ct = 1; pk = 0; tk(1);
    #1 pk = 1; tk(1);
    #1 ct = 0; tk(1);
    chk("R8 isolated hits", sw_en, 1);
    #1 ct = 1; tk(1);
    chk("R8 back-to-back stop", sw_en, 0); chk("R8 code", fcode, 3);
    #1 ct = 0; pk = 0; brst = 1; tk(3);
    chk("R9 latch holds chg", chg_en, 0); chk("R9 latch holds sw", sw_en, 0);
    #1 uv = 1; tk(2);
    chk("R9 released chg", chg_en, 1); chk("R9 slow current", chg_fast, 0);
    #1 uv = 0; brst = 0; above = 1; tk(1);
    chk("R7 restart sw", sw_en, 1); chk("R7 ramp from 0", ilim, 0);
    #1 above = 0; tk(STEPC);
    chk("R7 first step", ilim, 1);
    #1 ov = 1; tk(1);
    chk("R6 stop", sw_en, 0); chk("R12 sticky", fcode, 3);
    #1 ov = 0; tk(20);
    chk("R6 wait no charge", chg_en, 0);
    #1 brst = 1; tk(1);
    chk("R6 slow charge", chg_en, 1); chk("R6 reduced", chg_fast, 0);
    #1 brst = 0; vin_ok = 0; tk(1);
    chk("R2 vin low", chg_en, 0);
    #1 vin_ok = 1; above = 1; tk(1);
    #1 above = 0; tk(5);
    #1 hot = 1; tk(1);
    chk("R10 trip", sw_en, 0);
    #1 hot = 0; brst = 1; tk(1);
    #1 brst = 0; above = 1; tk(1);
    chk("R10 restart", sw_en, 1);
    #1 above = 0; tk(1);
    chk("R10 still hot", sw_en, 0);
    #1 cool = 1; tk(1);
    #1 cool = 0; brst = 1; tk(1);
    #1 brst = 0; above = 1; tk(1);
    #1 above = 0; tk(5);
    chk("R10 released", sw_en, 1);
    #1 uv = 1; ov = 1; tk(1);
    chk("R5 uv stop", sw_en, 0);
    #1 uv = 0; ov = 0; brst = 1; tk(3);
    #1 brst = 0; above = 1; tk(5);
    chk("R5 no restart sw", sw_en, 0); chk("R5 no restart chg", chg_en, 0);
    #1 above = 0; rst_n = 0; tk(2);
    #1 rst_n = 1; above = 1; tk(1);
    #1 above = 0; tk(3);
    #1 ov = 1; ol = 1; tk(1);
    chk("R12 priority", fcode, 2);
    #1 ov = 0; ol = 0; tk(3);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule